// File: doc/BRIEF.md
# I2C Converter Control Slave

This block is the bus-facing controller of a multichannel successive-approximation converter. It listens on a two-wire I2C bus as a slave only, and answers to a 7-bit address. The upper four bits of that address are a parameter and the lower three come from external select pins. A write transaction carries one control byte. That byte picks the input channel, stores a two-bit range code for that channel, and sets a power mode. A read transaction returns the most recent conversion result as two bytes.

The sampling window follows the bus. The track/hold output goes to track on the falling SCL edge that ends the sixth bit of an accepted control byte. It returns to hold when the master issues STOP, and a one-cycle conversion-start pulse is sent to the converter core at the same moment. The core is modelled as a result bus with a done strobe. SCL and SDA are brought into a system clock domain through two flip-flop stages, and that clock must run at eight or more times the SCL rate. SDA is open-drain: the block only pulls it low, through an output enable.

Top module: `adc_i2c_ctl`

## Requirements
- R1: After a START, the block compares the first 7 bits, sent MSB first, with {ADDR_HI, addr_sel}. The 8th bit is read/write, with 1 meaning read. On a match it pulls SDA low for the 9th clock. On a mismatch it leaves SDA released for the rest of the transaction, including any further bytes.
- R2: START is an SDA fall and STOP is an SDA rise, each while SCL stays high. The block has no SCL output.
- R3: th_track goes high after the falling SCL edge of the 6th bit of a control byte whose bit 7 is 1. It is still low after the 5th falling edge.
- R4: A STOP that follows an acknowledged control byte drops th_track to 0 and pulses conv_start high for exactly one clock cycle.
- R5: A STOP that arrives before all 8 control bits drops th_track to 0 and produces no conv_start.
- R6: A control byte with bit 7 equal to 0 gets no ACK, starts no tracking, stores nothing, and a later STOP starts no conversion.
- R7: The control byte fields are: bit 7 the start marker, bits 6:4 the channel, bit 3 the range bit, bit 2 the bipolar bit, bits 1:0 the power mode. An accepted byte stores {range, bipolar} into ch_ranges[2*ch+1:2*ch]. Other channels keep their codes. chan_sel and pwr_mode take the new fields.
- R8: A read returns result[11:4] first. If the master ACKs, the second byte is {result[3:0], 4'b0000}. After a NACK, or after the second byte, SDA stays released.
- R9: The result register loads conv_result in the cycle that conv_done is high.
- R10: After reset, SDA is released, th_track and conv_start are 0, and all range codes, chan_sel and pwr_mode are 0.
- R11: A repeated START restarts address decoding. It cancels a pending conversion and drops th_track, so a following STOP starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA drive value, always 0 |
| sda_oe | output | 1 | SDA pull-low enable |
| addr_sel | input | 3 | Low three bits of the slave address |
| th_track | output | 1 | 1 = track, 0 = hold |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_result | input | 12 | Result from the converter core |
| conv_done | input | 1 | Result valid strobe |
| chan_sel | output | 3 | Selected input channel |
| ch_ranges | output | 16 | Range code {range, bipolar} of each channel, channel 0 in the low bits |
| pwr_mode | output | 2 | Power mode from the last accepted control byte |

## Verification
The bench samples th_track before each SCL rising edge. A design that counts the sixth edge wrongly starts tracking one bit early or late, and the check on that exact bit catches it. Three cases each end in a STOP that must start no conversion: a STOP cut in after 7 control bits, a control byte without the marker bit, and a repeated START that follows an accepted byte. A design that keeps its pending flag set emits a stray conv_start, and the scoreboard finds no expected item for it. Reads end with a NACK followed by extra clocks. A design that keeps driving after the NACK corrupts the 0xFF the master expects. Several channels are written in turn, so a range bank with crossed write enables overwrites a neighbouring channel's code.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } bus_st_t;

  // control byte field positions (decoded by the range bank and outputs)
  localparam int CB_MARK  = 7;
  localparam int CB_CH_HI = 6;
  localparam int CB_CH_LO = 4;
  localparam int CB_RNG   = 3;
  localparam int CB_BIP   = 2;
  localparam int CB_PWR_HI = 1;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  always_comb begin
    scl_now   = scl_ff[SYNC_STAGES-1];
    sda_lvl   = sda_ff[SYNC_STAGES-1];
    scl_rise  = scl_now & ~scl_d;
    scl_fall  = ~scl_now & scl_d;
    start_det = scl_now & scl_d & sda_d & ~sda_lvl;
    stop_det  = scl_now & scl_d & ~sda_d & sda_lvl;
  end

endmodule

// File: rtl/adc_range_bank.sv
module adc_range_bank #(
  parameter int N_CH = 8,
  parameter int CODE_W = 2,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CH_W-1:0]        wr_ch,
  input  logic [CODE_W-1:0]      wr_code,
  output logic [N_CH*CODE_W-1:0] ranges_o
);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [CODE_W-1:0] code_q, code_d;
    logic we;

    always_comb begin
      we     = wr_en && (wr_ch == CH_W'(g));
      code_d = we ? wr_code : code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_d;
    end

    assign ranges_o[g*CODE_W +: CODE_W] = code_q;
  end

  a_r7_code_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ranges_o[$past(wr_ch)*CODE_W +: CODE_W] == $past(wr_code)));

endmodule

// File: rtl/i2c_ctl_fsm.sv
module i2c_ctl_fsm
  import adc_i2c_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0101,
  parameter int RES_W = 12,
  localparam int PAD_W = 16 - RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [2:0]       addr_sel,
  input  logic [RES_W-1:0] result,
  output logic             sda_oe,
  output logic             th_track,
  output logic             conv_start,
  output logic             wr_en,
  output logic [2:0]       chan_sel,
  output logic [1:0]       pwr_mode,
  output logic [1:0]       wr_code
);

  bus_st_t    state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       rw_q, rw_d, pend_q, pend_d, trk_q, trk_d, cs_q, cs_d;
  logic       mack_q, mack_d, second_q, second_d;
  logic [2:0] ch_q, ch_d;
  logic [1:0] pwr_q, pwr_d;
  logic [15:0] res_pad;

  assign res_pad = {result, {PAD_W{1'b0}}};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    pend_d   = pend_q;
    trk_d    = trk_q;
    cs_d     = 1'b0;
    mack_d   = mack_q;
    second_d = second_q;
    ch_d     = ch_q;
    pwr_d    = pwr_q;
    wr_en    = 1'b0;
    wr_code  = {sh_q[CB_RNG], sh_q[CB_BIP]};
    if (stop_det) begin
      state_d = ST_IDLE;
      cs_d    = pend_q;
      trk_d   = 1'b0;
      pend_d  = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      trk_d   = 1'b0;
      pend_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sh_q[7:1] == {ADDR_HI, addr_sel}) begin
              state_d = ST_ADDR_ACK;
              rw_d    = sh_q[0];
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d  = ST_TX;
              sh_d     = res_pad[15:8];
              second_d = 1'b0;
            end else begin
              state_d = ST_CTRL;
            end
          end
        end
        ST_CTRL: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd6 && sh_q[5]) trk_d = 1'b1;
            if (cnt_q == 4'd8) begin
              if (sh_q[CB_MARK]) begin
                state_d = ST_CTRL_ACK;
                wr_en   = 1'b1;
                ch_d    = sh_q[CB_CH_HI:CB_CH_LO];
                pwr_d   = sh_q[CB_PWR_HI:0];
                pend_d  = 1'b1;
              end else begin
                state_d = ST_IGNORE;
              end
            end
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall) state_d = ST_IGNORE;
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) state_d = ST_TX_ACK;
            else               sh_d = {sh_q[6:0], 1'b1};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q && !second_q) begin
              state_d  = ST_TX;
              cnt_d    = '0;
              second_d = 1'b1;
              sh_d     = res_pad[7:0];
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '1;
      rw_q     <= 1'b0;
      pend_q   <= 1'b0;
      trk_q    <= 1'b0;
      cs_q     <= 1'b0;
      mack_q   <= 1'b0;
      second_q <= 1'b0;
      ch_q     <= '0;
      pwr_q    <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rw_q     <= rw_d;
      pend_q   <= pend_d;
      trk_q    <= trk_d;
      cs_q     <= cs_d;
      mack_q   <= mack_d;
      second_q <= second_d;
      ch_q     <= ch_d;
      pwr_q    <= pwr_d;
    end
  end

  always_comb begin
    sda_oe = (state_q == ST_ADDR_ACK) || (state_q == ST_CTRL_ACK) ||
             ((state_q == ST_TX) && !sh_q[7]);
    th_track   = trk_q;
    conv_start = cs_q;
    chan_sel   = ch_q;
    pwr_mode   = pwr_q;
  end

  // R1: SDA drive only changes right after an SCL fall or a bus condition
  a_r1_oe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
  a_r3_track_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(th_track) |-> $past(scl_fall));
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r4_start_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !th_track);
  a_r4_start_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(stop_det));
  a_r11_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!th_track && !sda_oe));

endmodule

// File: rtl/adc_i2c_ctl.sv
module adc_i2c_ctl #(
  parameter logic [3:0] ADDR_HI = 4'b0101,
  parameter int RES_W = 12,
  parameter int N_CH = 8,
  localparam int CODE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_o,
  output logic                   sda_oe,
  input  logic [2:0]             addr_sel,
  output logic                   th_track,
  output logic                   conv_start,
  input  logic [RES_W-1:0]       conv_result,
  input  logic                   conv_done,
  output logic [2:0]             chan_sel,
  output logic [N_CH*CODE_W-1:0] ch_ranges,
  output logic [1:0]             pwr_mode
);

  logic [1:0] rst_pipe;
  logic rst_sn;
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [1:0] wr_code;
  logic [RES_W-1:0] res_q, res_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign sda_o = 1'b0;

  i2c_line_sync #(.SYNC_STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ctl_fsm #(.ADDR_HI(ADDR_HI), .RES_W(RES_W)) i_fsm (
    .clk(clk), .rst_n(rst_sn), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .result(res_q), .sda_oe(sda_oe),
    .th_track(th_track), .conv_start(conv_start), .wr_en(wr_en),
    .chan_sel(chan_sel), .pwr_mode(pwr_mode), .wr_code(wr_code)
  );

  adc_range_bank #(.N_CH(N_CH), .CODE_W(CODE_W)) i_bank (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en),
    .wr_ch(chan_sel_next(wr_en, chan_sel)), .wr_code(wr_code),
    .ranges_o(ch_ranges)
  );

  function automatic logic [$clog2(N_CH)-1:0] chan_sel_next(input logic en,
                                                            input logic [2:0] cur);
    chan_sel_next = en ? i_fsm.ch_d[$clog2(N_CH)-1:0] : cur[$clog2(N_CH)-1:0];
  endfunction

  always_comb res_d = conv_done ? conv_result : res_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) res_q <= '0;
    else         res_q <= res_d;
  end

  a_r9_result_latch: assert property (@(posedge clk) disable iff (!rst_sn)
    conv_done |=> (res_q == $past(conv_result)));

endmodule

// File: tb/test_adc_i2c_ctl.sv
module test_adc_i2c_ctl;

  typedef struct packed {
    logic [2:0]  ch;
    logic [11:0] res;
  } conv_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_o, sda_oe, th_track, conv_start, conv_done;
  logic [11:0] conv_result;
  logic [2:0] chan_sel;
  logic [15:0] ch_ranges;
  logic [1:0] pwr_mode;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  int conv_seen = 0;
  int done_cnt = 0;
  logic [11:0] pend_res = '0;
  conv_item_t exp_q[$];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  adc_i2c_ctl i_adc_i2c_ctl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .addr_sel(3'b010),
    .th_track(th_track), .conv_start(conv_start),
    .conv_result(conv_result), .conv_done(conv_done),
    .chan_sel(chan_sel), .ch_ranges(ch_ranges), .pwr_mode(pwr_mode)
  );

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: conversion strobes against queued expectations
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (done_cnt > 0) begin
      done_cnt--;
      if (done_cnt == 0) begin
        conv_result = pend_res;
        conv_done = 1'b1;
      end
    end
    if (rst_n && conv_start) begin
      conv_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected conv_start", 16'd1, 16'd0);
      end else begin
        conv_item_t it;
        it = exp_q.pop_front();
        chk(chan_sel == it.ch, "R7 chan_sel at conversion", {13'd0, chan_sel}, {13'd0, it.ch});
        chk(th_track == 1'b0, "R4 hold during start", {15'd0, th_track}, 16'd0);
        pend_res = it.res;
        done_cnt = 12;
      end
    end
  end

  task automatic bit_x(input logic b, output logic s, output logic t);
    wc(5); sda_m = b; wc(5);
    t = th_track;
    scl_m = 1'b1; wc(5);
    s = sda_bus; wc(5);
    scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; wc(5);
    sda_m = 1'b0; wc(5);
    scl_m = 1'b0;
  endtask

  task automatic i2c_rstart();
    wc(5); sda_m = 1'b1; wc(5);
    scl_m = 1'b1; wc(5);
    sda_m = 1'b0; wc(5);
    scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    wc(5); sda_m = 1'b0; wc(5);
    scl_m = 1'b1; wc(5);
    sda_m = 1'b1; wc(10);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack, output logic [8:0] trk);
    logic s, t;
    for (int i = 0; i < 8; i++) begin
      bit_x(b[7-i], s, t);
      trk[i] = t;
    end
    bit_x(1'b1, s, t);
    trk[8] = t;
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic s, t;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, s, t);
      v[7-i] = s;
    end
    bit_x(~mack, s, t);
  endtask

  localparam logic [7:0] A_WR = 8'h54;
  localparam logic [7:0] A_RD = 8'h55;
  localparam logic [7:0] A_BAD = 8'h56;

  initial begin
    logic ack;
    logic [8:0] trk;
    logic [7:0] v;
    logic s, t;
    int base;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    conv_done = 1'b0; conv_result = '0;
    wc(5);
    rst_n = 1'b1;
    wc(5);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10 sda released", {15'd0, sda_oe}, 16'd0);
    chk(th_track == 1'b0 && conv_start == 1'b0, "R10 track/start low",
        {14'd0, th_track, conv_start}, 16'd0);
    chk(ch_ranges == 16'd0 && pwr_mode == 2'd0 && chan_sel == 3'd0, "R10 ranges clear",
        ch_ranges, 16'd0);

    // write ch3, range=1 bipolar=0, power 01: 1_011_1_0_01
    i2c_start();
    wr_byte(A_WR, ack, trk);
    chk(ack, "R1 address ACK", {15'd0, ack}, 16'd1);
    wr_byte(8'b1011_1001, ack, trk);
    chk(ack, "R7 control byte ACK", {15'd0, ack}, 16'd1);
    chk(trk[5] == 1'b0, "R3 no track after 5th fall", {15'd0, trk[5]}, 16'd0);
    chk(trk[6] == 1'b1, "R3 track after 6th fall", {15'd0, trk[6]}, 16'd1);
    wc(8);
    chk(ch_ranges[7:6] == 2'b10, "R7 ch3 range code", {14'd0, ch_ranges[7:6]}, 16'd2);
    chk(pwr_mode == 2'b01 && chan_sel == 3'd3, "R7 fields", {11'd0, chan_sel, pwr_mode},
        {11'd0, 3'd3, 2'b01});
    exp_q.push_back('{ch: 3'd3, res: 12'hABC});
    i2c_stop();
    chk(th_track == 1'b0, "R4 hold after stop", {15'd0, th_track}, 16'd0);
    wc(30);
    chk(conv_seen == 1, "R4 one conversion", 16'(conv_seen), 16'd1);

    // R8 R9 read with ACK then NACK
    i2c_start();
    wr_byte(A_RD, ack, trk);
    chk(ack, "R1 read address ACK", {15'd0, ack}, 16'd1);
    rd_byte(1'b1, v);
    chk(v == 8'hAB, "R8 high byte", {8'd0, v}, 16'h00AB);
    rd_byte(1'b0, v);
    chk(v == 8'hC0, "R8 low byte left-justified", {8'd0, v}, 16'h00C0);
    rd_byte(1'b0, v);
    chk(v == 8'hFF, "R8 released after last byte", {8'd0, v}, 16'h00FF);
    i2c_stop();

    // write ch5: range=0 bipolar=1, power 10
    i2c_start();
    wr_byte(A_WR, ack, trk);
    wr_byte(8'b1101_0110, ack, trk);
    chk(ack, "R7 second control ACK", {15'd0, ack}, 16'd1);
    exp_q.push_back('{ch: 3'd5, res: 12'h5A3});
    i2c_stop();
    wc(30);
    chk(ch_ranges == 16'h0480, "R7 per-channel codes kept", ch_ranges, 16'h0480);
    chk(pwr_mode == 2'b10, "R7 power mode", {14'd0, pwr_mode}, 16'd2);

    // R1 wrong address
    base = conv_seen;
    i2c_start();
    wr_byte(A_BAD, ack, trk);
    chk(!ack, "R1 mismatch NACK", {15'd0, ack}, 16'd0);
    wr_byte(8'b1111_1111, ack, trk);
    chk(!ack && trk == 9'd0, "R1 ignored after mismatch", {6'd0, ack, trk}, 16'd0);
    i2c_stop();
    wc(20);
    chk(conv_seen == base && ch_ranges == 16'h0480, "R1 no effect", ch_ranges, 16'h0480);

    // R5 STOP after 7 control bits
    i2c_start();
    wr_byte(A_WR, ack, trk);
    for (int i = 0; i < 7; i++) bit_x((i == 0) ? 1'b1 : 1'b0, s, t);
    wc(8);
    chk(th_track == 1'b1, "R3 tracking in partial byte", {15'd0, th_track}, 16'd1);
    i2c_stop();
    chk(th_track == 1'b0, "R5 track released", {15'd0, th_track}, 16'd0);
    wc(20);
    chk(conv_seen == base && ch_ranges == 16'h0480, "R5 no conversion",
        16'(conv_seen - base), 16'd0);

    // R6 marker clear: 0_110_1_1_00
    i2c_start();
    wr_byte(A_WR, ack, trk);
    wr_byte(8'b0110_1100, ack, trk);
    chk(!ack, "R6 no ACK without marker", {15'd0, ack}, 16'd0);
    chk(trk == 9'd0, "R6 no tracking", {7'd0, trk}, 16'd0);
    i2c_stop();
    wc(20);
    chk(conv_seen == base && ch_ranges == 16'h0480 && pwr_mode == 2'b10,
        "R6 nothing stored or started", ch_ranges, 16'h0480);

    // R11 repeated START cancels pending conversion: ch0 code 11
    i2c_start();
    wr_byte(A_WR, ack, trk);
    wr_byte(8'b1000_1100, ack, trk);
    chk(ack, "R11 control ACK before restart", {15'd0, ack}, 16'd1);
    i2c_rstart();
    wc(6);
    chk(th_track == 1'b0, "R11 track dropped on restart", {15'd0, th_track}, 16'd0);
    wr_byte(A_RD, ack, trk);
    chk(ack, "R11 address decoded after restart", {15'd0, ack}, 16'd1);
    rd_byte(1'b1, v);
    chk(v == 8'h5A, "R9 latest result high", {8'd0, v}, 16'h005A);
    rd_byte(1'b0, v);
    chk(v == 8'h30, "R8 latest result low", {8'd0, v}, 16'h0030);
    i2c_stop();
    wc(30);
    chk(conv_seen == base, "R11 no conversion after restart", 16'(conv_seen - base), 16'd0);
    chk(ch_ranges == 16'h0483, "R7 ch0 stored at ACK", ch_ranges, 16'h0483);

    // R2 START/STOP only while SCL high: SDA toggles with SCL low are data
    i2c_start();
    wr_byte(A_RD, ack, trk);
    rd_byte(1'b0, v);
    chk(v == 8'h5A, "R2 transaction intact", {8'd0, v}, 16'h005A);
    i2c_stop();

    chk(exp_q.size() == 0, "R4 all expected conversions seen", 16'(exp_q.size()), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule